// File: doc/BRIEF.md
# Sub-pixel sinc line shifter

The block moves one image line by a fraction of a pixel. It runs the samples of the line through a 21-tap FIR window whose coefficients are a damped sinc that is computed elsewhere. Each input word is 64 bits wide and carries two signed Q16.16 samples. The coefficients are written beforehand through a separate load port. They stay in tap registers and are reused by every later line. Where the window reaches past either end of the line, a programmable hole value takes the place of the missing samples.

A `start` pulse latches the line length in words, the hole value and the bypass flag. Input words then enter through a valid/ready handshake. Results leave as 64-bit words that each hold two filtered samples, together with the word address they belong to. A `done` pulse closes the line. When the fractional shift is negligible, the controlling logic sets bypass and each word is copied unchanged to its own address.

Top module: `sinc_line_shifter`

## Requirements
- R1: After reset, `out_valid`, `done` and `in_ready` are all 0.
- R2: Each `coef_we` cycle taken while idle moves the 22-entry coefficient chain down by two entries and writes `coef_word[31:0]` into entry 20 and `coef_word[63:32]` into entry 21. After 11 words, tap t (0..20) holds word t/2, in the low half when t is even and the high half when t is odd. A `coef_we` that arrives while a line is in progress is ignored.
- R3: The coefficients persist from one line to the next without a reload.
- R4: Filtered sample q equals the sum over t = 0..20 of tap[t]·x[q−10+t], where x is the line's sample sequence.
- R5: Any neighbour x[i] with i < 0 or i ≥ 2n, where n is the line length in words, is replaced by the `hole` value latched at `start`.
- R6: Input word w carries sample 2w in bits [31:0] and sample 2w+1 in bits [63:32]. Output word a at `out_addr` = a carries result 2a in bits [31:0] and result 2a+1 in bits [63:32].
- R7: `in_ready` is high only while the block waits for the next input word. Gaps in `in_valid` stall the line without changing results. The block takes exactly n words, and `in_ready` is 0 once they have all been taken.
- R8: Products are summed in a 48-bit accumulator. The sum is rounded to Q16.16 by adding 2^15 and shifting right arithmetically by 16.
- R9: With `bypass` latched at `start`, each input word is written unchanged to its own word address.
- R10: Every address 0..n−1 is written exactly once per line. `done` is a single-cycle pulse in the cycle after the last output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Load one coefficient word |
| coef_word | input | 64 | Two Q16.16 coefficients, low half first |
| start | input | 1 | Begin a line; ignored while busy |
| line_len | input | 10 | Line length n in 64-bit words (n ≥ 1) |
| bypass | input | 1 | Copy the line unchanged |
| hole | input | 32 | Substitute for samples beyond the line ends |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts an input word |
| in_word | input | 64 | Two input samples |
| out_valid | output | 1 | Output word valid |
| out_addr | output | 10 | Word address of the output |
| out_word | output | 64 | Two filtered samples |
| done | output | 1 | Line finished |

## Verification
A single centre tap at 1.0 must return the input unchanged, which pins down the window centring and the half-word order. Taps placed at both outer ends reach beyond both ends of the line, so every result mixes real samples with the hole value. An asymmetric set of fractional taps fed with gaps in `in_valid` exposes any reversal of the coefficient order, any slip of the window, and any stall that drops or repeats a sample. A half-weight tap applied to ±1 LSB inputs separates round-half-up from truncation, and the tests also cover a one-word line, a coefficient load attempted mid-line, a reused coefficient set, and bypass with non-trivial taps.

// File: rtl/sinc_pkg.sv
`timescale 1ns/1ps
package sinc_pkg;
  localparam int SMP_W  = 32;  // sample and coefficient width
  localparam int FRAC_W = 16;  // fractional bits
  localparam int NTAPS  = 21;  // filter taps
  localparam int CHAIN  = 22;  // coefficient chain entries (two per word)
  localparam int ACC_W  = 48;  // accumulator width
  localparam int CENTER = 10;  // centre tap index
endpackage

// File: rtl/sinc_coef_bank.sv
`timescale 1ns/1ps
module sinc_coef_bank #(
  parameter int DW    = 32,
  parameter int CREG  = 22,
  parameter int TAPS  = 21
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [2*DW-1:0]      word,
  output logic signed [DW-1:0] taps [TAPS]
);
  logic signed [DW-1:0] c [CREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CREG; i++) c[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < CREG-2; i++) c[i] <= c[i+2];
      c[CREG-2] <= word[DW-1:0];
      c[CREG-1] <= word[2*DW-1:DW];
    end
  end

  generate
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign taps[t] = c[t];
    end
  endgenerate

  // R2
  coef_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (c[CREG-1] == $past(word[2*DW-1:DW])) && (c[CREG-2] == $past(word[DW-1:0])));
  // R3
  coef_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(c[0]) && $stable(c[CREG-1]));
endmodule

// File: rtl/sinc_window.sv
`timescale 1ns/1ps
module sinc_window #(
  parameter int DW   = 32,
  parameter int TAPS = 21
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic [DW-1:0]        clr_val,
  input  logic                 push,
  input  logic [DW-1:0]        din,
  output logic signed [DW-1:0] win [TAPS]
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) win[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < TAPS; i++) win[i] <= clr_val;
    end else if (push) begin
      for (int i = 0; i < TAPS-1; i++) win[i] <= win[i+1];
      win[TAPS-1] <= din;
    end
  end

  // R5
  win_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (win[0] == $past(clr_val)) && (win[TAPS-1] == $past(clr_val)));
  // R4
  win_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !clr) |=> (win[TAPS-1] == $past(din)) && (win[0] == $past(win[1])));
endmodule

// File: rtl/sinc_mac.sv
`timescale 1ns/1ps
module sinc_mac #(
  parameter int DW    = 32,
  parameter int FRAC  = 16,
  parameter int TAPS  = 21,
  parameter int AW    = 48
) (
  input  logic signed [DW-1:0] win  [TAPS],
  input  logic signed [DW-1:0] coef [TAPS],
  output logic signed [DW-1:0] res
);
  logic signed [AW-1:0] prod [TAPS];
  logic signed [AW-1:0] acc;

  generate
    for (genvar t = 0; t < TAPS; t++) begin : g_mul
      assign prod[t] = AW'(win[t]) * AW'(coef[t]);
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int t = 0; t < TAPS; t++) acc = acc + prod[t];
  end

  assign res = DW'((acc + AW'(1 <<< (FRAC-1))) >>> FRAC);
endmodule

// File: rtl/sinc_line_shifter.sv
`timescale 1ns/1ps
module sinc_line_shifter
  import sinc_pkg::*;
#(
  parameter int LW   = 10,
  parameter int DW   = SMP_W,
  parameter int FRAC = FRAC_W,
  parameter int TAPS = NTAPS,
  parameter int CREG = CHAIN,
  parameter int AW   = ACC_W,
  parameter int CTR  = CENTER
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            coef_we,
  input  logic [63:0]     coef_word,
  input  logic            start,
  input  logic [LW-1:0]   line_len,
  input  logic            bypass,
  input  logic [31:0]     hole,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [63:0]     in_word,
  output logic            out_valid,
  output logic [LW-1:0]   out_addr,
  output logic [63:0]     out_word,
  output logic            done
);
  localparam int WW  = 2*DW;
  localparam int SW  = LW + 2;
  localparam int JW  = LW + 1;
  localparam int LAG = CTR / 2;

  logic            busy, run, byp_r;
  logic [LW-1:0]   n_r;
  logic [DW-1:0]   hole_r, hi_r;
  logic signed [DW-1:0] lo_r;
  logic [SW-1:0]   s, last_s;
  logic            k, have_word, need_word, step_go, byp_take, take;
  logic [JW-1:0]   j, j1;
  logic            v1, k1;
  logic [DW-1:0]   smp;
  logic signed [DW-1:0] taps [TAPS];
  logic signed [DW-1:0] win  [TAPS];
  logic signed [DW-1:0] mac_q;

  assign k         = s[0];
  assign j         = s[SW-1:1];
  assign have_word = j < {1'b0, n_r};
  assign need_word = !k && have_word;
  assign step_go   = run && !byp_r && (!need_word || in_valid);
  assign byp_take  = run && byp_r && in_valid;
  assign in_ready  = run && (byp_r || need_word);
  assign take      = start && !busy;
  assign last_s    = byp_r ? ({2'b0, n_r} - SW'(1))
                           : ({1'b0, n_r, 1'b0} + SW'(2*CTR - 1 - CTR));
  assign smp       = !have_word ? hole_r : (k ? hi_r : in_word[DW-1:0]);

  sinc_coef_bank #(.DW(DW), .CREG(CREG), .TAPS(TAPS)) u_coef (
    .clk(clk), .rst(rst), .load(coef_we && !busy), .word(coef_word[WW-1:0]), .taps(taps)
  );

  sinc_window #(.DW(DW), .TAPS(TAPS)) u_win (
    .clk(clk), .rst(rst), .clr(take), .clr_val(hole[DW-1:0]),
    .push(step_go), .din(smp), .win(win)
  );

  sinc_mac #(.DW(DW), .FRAC(FRAC), .TAPS(TAPS), .AW(AW)) u_mac (
    .win(win), .coef(taps), .res(mac_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; run <= 1'b0; byp_r <= 1'b0; n_r <= '0; hole_r <= '0;
      hi_r <= '0; lo_r <= '0; s <= '0; v1 <= 1'b0; k1 <= 1'b0; j1 <= '0;
      out_valid <= 1'b0; out_addr <= '0; out_word <= '0; done <= 1'b0;
    end else begin
      done      <= 1'b0;
      out_valid <= 1'b0;
      v1        <= step_go;
      k1        <= k;
      j1        <= j;
      if (take) begin
        busy <= 1'b1; run <= 1'b1; s <= '0;
        n_r <= line_len; hole_r <= hole[DW-1:0]; byp_r <= bypass;
      end else begin
        if (step_go || byp_take) begin
          s <= s + SW'(1);
          if (s == last_s) run <= 1'b0;
        end
        if (step_go && need_word) hi_r <= in_word[WW-1:DW];
        if (byp_take) begin
          out_valid <= 1'b1;
          out_word  <= in_word;
          out_addr  <= s[LW-1:0];
        end
        if (v1 && !k1) lo_r <= mac_q;
        if (v1 && k1 && (j1 >= JW'(LAG))) begin
          out_valid <= 1'b1;
          out_word  <= {mac_q, lo_r};
          out_addr  <= LW'(j1 - JW'(LAG));
        end
        if (busy && out_valid && (out_addr == n_r - LW'(1))) begin
          done <= 1'b1;
          busy <= 1'b0;
        end
      end
    end
  end

  // R10
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_addr < n_r));
  // R10
  done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_valid));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7
  ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> busy);
endmodule

// File: tb/sinc_line_shifter_bench.sv
`timescale 1ns/1ps
module sinc_line_shifter_bench;
  localparam int LW   = 10;
  localparam int MAXW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coef_we = 1'b0;
  logic [63:0] coef_word = '0;
  logic start = 1'b0;
  logic [LW-1:0] line_len = '0;
  logic bypass = 1'b0;
  logic [31:0] hole = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [63:0] in_word = '0;
  logic out_valid;
  logic [LW-1:0] out_addr;
  logic [63:0] out_word;
  logic done;

  always #2.5 clk = ~clk;

  sinc_line_shifter #(.LW(LW)) u_sinc_line_shifter (
    .clk(clk), .rst(rst), .coef_we(coef_we), .coef_word(coef_word),
    .start(start), .line_len(line_len), .bypass(bypass), .hole(hole),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_addr(out_addr), .out_word(out_word), .done(done)
  );

  int total = 0, bad = 0, cyc = 0;
  int xs [0:2*MAXW-1];
  int cf [0:21];
  logic [63:0] got [0:MAXW-1];
  int wr [0:MAXW-1];
  int last_cyc, done_cyc, done_cnt;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid && out_addr < MAXW) begin
      got[out_addr] = out_word;
      wr[out_addr]  = wr[out_addr] + 1;
      last_cyc      = cyc;
    end
    if (done) begin
      done_cyc = cyc;
      done_cnt = done_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int conv(input int q, input int n, input int hv);
    longint acc = 0;
    for (int t = 0; t < 21; t++) begin
      int idx = q - 10 + t;
      longint v = (idx < 0 || idx >= 2*n) ? longint'(hv) : longint'(xs[idx]);
      acc += longint'(cf[t]) * v;
    end
    return int'((acc + 64'sd32768) >>> 16);
  endfunction

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < 2*n; i++)
      xs[i] = ((i*7 + seed) % 23 - 11) * 65536 + ((i*913 + seed*31) % 65536) - 32768;
  endtask

  task automatic load_coefs();
    for (int w = 0; w < 11; w++) begin
      @(negedge clk);
      coef_we   = 1'b1;
      coef_word = {cf[2*w+1], cf[2*w]};
    end
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic set_coefs(input int sel);
    for (int t = 0; t < 22; t++) cf[t] = 0;
    case (sel)
      0: cf[10] = 32'h0001_0000;
      1: begin cf[0] = 32'h0001_0000; cf[20] = 32'h0000_8000; end
      2: for (int t = 0; t < 21; t++) cf[t] = (t*5003 % 40000) - 12000 + t*t*97;
      default: cf[10] = 32'h0000_8000;
    endcase
  endtask

  task automatic run_line(input int n, input bit byp, input int hv, input bit gaps,
                          input bit junk, input string req);
    bit rdy;
    for (int a = 0; a < MAXW; a++) begin wr[a] = 0; got[a] = '0; end
    done_cnt = 0;
    @(negedge clk);
    line_len = LW'(n); bypass = byp; hole = hv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int w = 0; w < n; w++) begin
      rdy = 1'b0;
      if (junk && w == 0) begin coef_we = 1'b1; coef_word = '1; end
      while (!rdy) begin
        in_valid = 1'b1;
        in_word  = {xs[2*w+1], xs[2*w]};
        rdy      = in_ready;
        @(negedge clk);
        coef_we  = 1'b0;
      end
      in_valid = 1'b0;
      if (gaps) repeat (w % 3) @(negedge clk);
    end
    in_valid = 1'b0;
    if (!byp) check(in_ready == 1'b0, "R7", "ready after last word", {63'd0, in_ready}, 64'd0);
    for (int c = 0; c < 2000 && done_cnt == 0; c++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(done_cnt == 1, "R10", "done pulses", 64'(done_cnt), 64'd1);
    check(done_cyc == last_cyc + 1, "R10", "done timing", 64'(done_cyc), 64'(last_cyc + 1));
    for (int a = 0; a < n; a++) begin
      logic [63:0] e;
      e = byp ? {xs[2*a+1], xs[2*a]} : {conv(2*a+1, n, hv), conv(2*a, n, hv)};
      check(wr[a] == 1, "R10", $sformatf("writes to addr %0d", a), 64'(wr[a]), 64'd1);
      check(got[a] == e, req, $sformatf("word %0d", a), got[a], e);
    end
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1", "out_valid", {63'd0, out_valid}, 64'd0);
    check(done == 1'b0, "R1", "done", {63'd0, done}, 64'd0);
    check(in_ready == 1'b0, "R1", "in_ready", {63'd0, in_ready}, 64'd0);
  endtask

  task automatic t_identity();   // R4 R6 centre tap returns input
    set_coefs(0); load_coefs(); fill(5, 3);
    run_line(5, 1'b0, 32'h0001_2345, 1'b0, 1'b0, "R4/R6 identity");
  endtask

  task automatic t_edges();      // R5 outer taps reach both ends
    set_coefs(1); load_coefs(); fill(6, 11);
    run_line(6, 1'b0, 32'hFFFD_4000, 1'b0, 1'b0, "R5 hole edges");
    fill(1, 5);
    run_line(1, 1'b0, 32'h0002_0000, 1'b0, 1'b0, "R5 one-word line");
  endtask

  task automatic t_general();    // R2 order, R4, R7 stalls
    set_coefs(2); load_coefs(); fill(9, 7);
    run_line(9, 1'b0, 32'h0000_7000, 1'b1, 1'b0, "R2/R4/R7 asymmetric taps with gaps");
  endtask

  task automatic t_reuse();      // R2 mid-line load ignored, R3 reuse
    fill(7, 19);
    run_line(7, 1'b0, 32'h0, 1'b0, 1'b1, "R2 load while busy ignored");
    fill(4, 23);
    run_line(4, 1'b0, 32'h0003_0000, 1'b1, 1'b0, "R3 coefficients reused");
  endtask

  task automatic t_round();      // R8 half-weight on +-1 LSB
    set_coefs(3); load_coefs();
    xs[0] = 1; xs[1] = -1; xs[2] = 3; xs[3] = -3; xs[4] = 32'h0001_0001; xs[5] = 0;
    run_line(3, 1'b0, 1, 1'b0, 1'b0, "R8 rounding");
    check(got[0][31:0] == 32'd1, "R8", "+1 LSB * 0.5", {32'd0, got[0][31:0]}, 64'd1);
    check(got[0][63:32] == 32'd0, "R8", "-1 LSB * 0.5", {32'd0, got[0][63:32]}, 64'd0);
  endtask

  task automatic t_bypass();     // R9 copy despite non-trivial taps
    set_coefs(2); load_coefs(); fill(8, 29);
    run_line(8, 1'b1, 32'h5555_0000, 1'b1, 1'b0, "R9 bypass");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_identity();
    t_edges();
    t_general();
    t_reuse();
    t_round();
    t_bypass();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule